// File: doc/BRIEF.md
# Write-Readback Bus Test Sequencer

This block runs a self-contained memory test over a register-addressed serial bus. It does not drive the bus wires itself. It hands one transaction at a time to a bus engine through a request port and takes a single response back for each request. After a start pulse it runs a set number of iterations. In each iteration it writes a data byte to a register address, waits for the write response, and then stays idle for a programmable number of cycles so the bus can settle. It then reads the same address back and compares the byte it gets with the byte it wrote.

In random mode both the address and the data come from a seeded 16-bit LFSR, so the same seed always replays the same test. The address is taken from a parameter list that contains only writable locations. In directed mode the address walks a fixed second list in order, and the data still comes from the LFSR. The block keeps a pass count, a fail count and the address of the most recent failure. It pulses a done flag when the run ends.

Top module: `wrbt_top`

## Requirements
- R1: A `start` pulse seen while the block is idle clears both counters and `last_fail_addr`, latches `iter_count`, `gap_cycles` and `directed`, and loads `seed` into the LFSR. A seed of zero is replaced by 16'h0001.
- R2: The LFSR steps as next = {s[14:0], s[15]^s[13]^s[12]^s[10]} once per iteration, after it has been used. In random mode the write address is list entry (s mod 5) of the default allow-list {0x10, 0x11, 0x22, 0x35, 0x4A}, entry 0 first, and the write data is s[7:0].
- R3: Each iteration issues a one-cycle write request (`req_write`=1) and then, unless the write was refused, a one-cycle read request (`req_write`=0) to the same address. At most one request is outstanding at a time.
- R4: With a gap setting of G, the read request is high exactly G+2 cycles after the cycle in which the write response is presented.
- R5: An iteration counts as a pass only when the read response carries no NACK and its data equals the written byte. Any other outcome counts as a fail.
- R6: A NACK on the write response ends the iteration as a fail with no read request issued. The next iteration then starts.
- R7: `last_fail_addr` holds the address of the most recent failing iteration. It is 0 after reset and after a start.
- R8: In directed mode, iteration i (counting from 0) uses address entry (i mod 3) of the default directed list {0x80, 0x81, 0xC0}. None of these addresses is in the allow-list.
- R9: `done` is high for exactly one cycle when the last iteration has finished, or in the cycle after the start if `iter_count` is 0. The counters and `last_fail_addr` then hold until the next start.
- R10: A `start` pulse that arrives while a run is in progress is ignored.
- R11: After reset, `done`, `req_valid`, both counters and `last_fail_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts a run |
| seed | input | 16 | LFSR seed loaded at start |
| iter_count | input | CNT_W | Number of iterations in the run |
| gap_cycles | input | GAP_W | Extra idle cycles between write response and read |
| directed | input | 1 | 1 selects the fixed address sequence |
| req_valid | output | 1 | One-cycle transaction request |
| req_write | output | 1 | 1 for write, 0 for read |
| req_addr | output | AW | Register address of the request |
| req_wdata | output | DW | Write data |
| rsp_valid | input | 1 | One-cycle response from the bus engine |
| rsp_nack | input | 1 | Response reports that the target refused the transfer |
| rsp_rdata | input | DW | Read data of a read response |
| pass_count | output | CNT_W | Passing iterations in the current or last run |
| fail_count | output | CNT_W | Failing iterations in the current or last run |
| done | output | 1 | One-cycle end-of-run flag |
| last_fail_addr | output | AW | Address of the most recent failure |

## Verification
If the LFSR state or the directed index goes wrong, the address or data on the very next write request already differs from the value the bench predicts, so the error is caught within one iteration. If the gap counter is off, the timing of the next read request moves by whole cycles, and the exact G+2 check catches it. A bad compare or a lost NACK shows up in the counters and in `last_fail_addr` at `done`. Faults are injected at chosen addresses so that both outcomes are exercised. A bad iteration counter shows up as `done` arriving at the wrong time, or as counts that do not add up to the number of iterations requested.

// File: rtl/wrbt_pkg.sv
package wrbt_pkg;

  localparam int RND_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PICK  = 3'd1,
    ST_WWAIT = 3'd2,
    ST_GAP   = 3'd3,
    ST_RWAIT = 3'd4,
    ST_NEXT  = 3'd5
  } seq_state_t;

  // Fibonacci form, taps 16,14,13,11
  function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
    return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/wrbt_lfsr.sv
module wrbt_lfsr
  import wrbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RND_W-1:0] seed,
  input  logic             step,
  output logic [RND_W-1:0] value
);

  logic [RND_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RND_W'(1);
    end else if (load) begin
      state_q <= (seed == '0) ? RND_W'(1) : seed;
    end else if (step) begin
      state_q <= rnd_step(state_q);
    end
  end

  assign value = state_q;

  // a valid maximal-length register never reaches the all-zero lockup state
  assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  // stepping moves the state exactly one position along the sequence
  assert_lfsr_step_R2: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (state_q[RND_W-1:1] == $past(state_q[RND_W-2:0])));

endmodule

// File: rtl/wrbt_addr_sel.sv
module wrbt_addr_sel
  import wrbt_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LIST_N = 5,
  parameter int DIR_N  = 3,
  parameter int DIR_IW = 2,
  parameter logic [LIST_N*AW-1:0] ALLOW_LIST = '0,
  parameter logic [DIR_N*AW-1:0]  DIR_LIST   = '0
) (
  input  logic [RND_W-1:0]  rnd,
  input  logic [DIR_IW-1:0] dir_idx,
  input  logic              directed,
  output logic [AW-1:0]     addr
);

  logic [AW-1:0] allow_rom [LIST_N];
  logic [AW-1:0] dir_rom   [DIR_N];

  for (genvar g = 0; g < LIST_N; g++) begin : g_allow
    assign allow_rom[g] = ALLOW_LIST[g*AW +: AW];
  end
  for (genvar g = 0; g < DIR_N; g++) begin : g_dir
    assign dir_rom[g] = DIR_LIST[g*AW +: AW];
  end

  logic [RND_W-1:0] rem;
  assign rem = rnd % RND_W'(LIST_N);

  logic [AW-1:0] rnd_addr, dir_addr;

  always_comb begin
    rnd_addr = allow_rom[0];
    for (int i = 0; i < LIST_N; i++) begin
      if (rem == RND_W'(i)) rnd_addr = allow_rom[i];
    end
  end

  always_comb begin
    dir_addr = dir_rom[0];
    for (int i = 0; i < DIR_N; i++) begin
      if (dir_idx == DIR_IW'(i)) dir_addr = dir_rom[i];
    end
  end

  assign addr = directed ? dir_addr : rnd_addr;

endmodule

// File: rtl/wrbt_seq_fsm.sv
module wrbt_seq_fsm
  import wrbt_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 8,
  parameter int CNT_W  = 16,
  parameter int GAP_W  = 8,
  parameter int DIR_N  = 3,
  parameter int DIR_IW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  iter_count,
  input  logic [GAP_W-1:0]  gap_cycles,
  input  logic              directed,
  input  logic [RND_W-1:0]  rnd,
  input  logic [AW-1:0]     pick_addr,
  output logic              rnd_load,
  output logic              rnd_step_en,
  output logic [DIR_IW-1:0] dir_idx,
  output logic              mode_dir,
  output logic              req_valid,
  output logic              req_write,
  output logic [AW-1:0]     req_addr,
  output logic [DW-1:0]     req_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_nack,
  input  logic [DW-1:0]     rsp_rdata,
  output logic [CNT_W-1:0]  pass_count,
  output logic [CNT_W-1:0]  fail_count,
  output logic              done,
  output logic [AW-1:0]     last_fail_addr
);

  seq_state_t       state_q;
  logic [CNT_W-1:0] iters_q, left_q;
  logic [GAP_W-1:0] gap_q, gap_cnt_q;
  logic [AW-1:0]    cur_addr_q;
  logic [DW-1:0]    cur_data_q;

  assign rnd_load    = start && (state_q == ST_IDLE);
  assign rnd_step_en = (state_q == ST_PICK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      iters_q        <= '0;
      left_q         <= '0;
      gap_q          <= '0;
      gap_cnt_q      <= '0;
      cur_addr_q     <= '0;
      cur_data_q     <= '0;
      dir_idx        <= '0;
      mode_dir       <= 1'b0;
      req_valid      <= 1'b0;
      req_write      <= 1'b0;
      req_addr       <= '0;
      req_wdata      <= '0;
      pass_count     <= '0;
      fail_count     <= '0;
      done           <= 1'b0;
      last_fail_addr <= '0;
    end else begin
      req_valid <= 1'b0;
      done      <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            iters_q        <= iter_count;
            left_q         <= iter_count;
            gap_q          <= gap_cycles;
            mode_dir       <= directed;
            dir_idx        <= '0;
            pass_count     <= '0;
            fail_count     <= '0;
            last_fail_addr <= '0;
            if (iter_count == '0) done <= 1'b1;
            else state_q <= ST_PICK;
          end
        end
        ST_PICK: begin
          cur_addr_q <= pick_addr;
          cur_data_q <= rnd[DW-1:0];
          req_valid  <= 1'b1;
          req_write  <= 1'b1;
          req_addr   <= pick_addr;
          req_wdata  <= rnd[DW-1:0];
          state_q    <= ST_WWAIT;
        end
        ST_WWAIT: begin
          if (rsp_valid) begin
            if (rsp_nack) begin
              fail_count     <= fail_count + 1'b1;
              last_fail_addr <= cur_addr_q;
              state_q        <= ST_NEXT;
            end else begin
              gap_cnt_q <= gap_q;
              state_q   <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gap_cnt_q == '0) begin
            req_valid <= 1'b1;
            req_write <= 1'b0;
            req_addr  <= cur_addr_q;
            state_q   <= ST_RWAIT;
          end else begin
            gap_cnt_q <= gap_cnt_q - 1'b1;
          end
        end
        ST_RWAIT: begin
          if (rsp_valid) begin
            if (!rsp_nack && rsp_rdata == cur_data_q) begin
              pass_count <= pass_count + 1'b1;
            end else begin
              fail_count     <= fail_count + 1'b1;
              last_fail_addr <= cur_addr_q;
            end
            state_q <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (left_q == CNT_W'(1)) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            left_q  <= left_q - 1'b1;
            dir_idx <= (dir_idx == DIR_IW'(DIR_N - 1)) ? '0 : dir_idx + 1'b1;
            state_q <= ST_PICK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_single_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  assert_gap_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_GAP && gap_cnt_q != '0) |=> !req_valid);

  assert_tally_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NEXT) |->
      ({1'b0, pass_count} + {1'b0, fail_count} ==
       {1'b0, iters_q} - {1'b0, left_q} + (CNT_W+1)'(1)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_hold_after_done_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !start) |=> ($stable(pass_count) && $stable(fail_count)));

endmodule

// File: rtl/wrbt_top.sv
module wrbt_top
  import wrbt_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 8,
  parameter int CNT_W  = 16,
  parameter int GAP_W  = 8,
  parameter int LIST_N = 5,
  parameter int DIR_N  = 3,
  parameter logic [LIST_N*AW-1:0] ALLOW_LIST = {8'h4A, 8'h35, 8'h22, 8'h11, 8'h10},
  parameter logic [DIR_N*AW-1:0]  DIR_LIST   = {8'hC0, 8'h81, 8'h80}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [15:0]      seed,
  input  logic [CNT_W-1:0] iter_count,
  input  logic [GAP_W-1:0] gap_cycles,
  input  logic             directed,
  output logic             req_valid,
  output logic             req_write,
  output logic [AW-1:0]    req_addr,
  output logic [DW-1:0]    req_wdata,
  input  logic             rsp_valid,
  input  logic             rsp_nack,
  input  logic [DW-1:0]    rsp_rdata,
  output logic [CNT_W-1:0] pass_count,
  output logic [CNT_W-1:0] fail_count,
  output logic             done,
  output logic [AW-1:0]    last_fail_addr
);

  localparam int DIR_IW = (DIR_N > 1) ? $clog2(DIR_N) : 1;

  logic [RND_W-1:0]  rnd;
  logic              rnd_load, rnd_step_en, mode_dir;
  logic [DIR_IW-1:0] dir_idx;
  logic [AW-1:0]     pick_addr;

  wrbt_lfsr u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .load  (rnd_load),
    .seed  (seed),
    .step  (rnd_step_en),
    .value (rnd)
  );

  wrbt_addr_sel #(
    .AW(AW), .LIST_N(LIST_N), .DIR_N(DIR_N), .DIR_IW(DIR_IW),
    .ALLOW_LIST(ALLOW_LIST), .DIR_LIST(DIR_LIST)
  ) u_sel (
    .rnd      (rnd),
    .dir_idx  (dir_idx),
    .directed (mode_dir),
    .addr     (pick_addr)
  );

  wrbt_seq_fsm #(
    .AW(AW), .DW(DW), .CNT_W(CNT_W), .GAP_W(GAP_W),
    .DIR_N(DIR_N), .DIR_IW(DIR_IW)
  ) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .iter_count     (iter_count),
    .gap_cycles     (gap_cycles),
    .directed       (directed),
    .rnd            (rnd),
    .pick_addr      (pick_addr),
    .rnd_load       (rnd_load),
    .rnd_step_en    (rnd_step_en),
    .dir_idx        (dir_idx),
    .mode_dir       (mode_dir),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .rsp_valid      (rsp_valid),
    .rsp_nack       (rsp_nack),
    .rsp_rdata      (rsp_rdata),
    .pass_count     (pass_count),
    .fail_count     (fail_count),
    .done           (done),
    .last_fail_addr (last_fail_addr)
  );

  function automatic logic in_allow(input logic [AW-1:0] a);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < LIST_N; i++) begin
      if (ALLOW_LIST[i*AW +: AW] == a) hit = 1'b1;
    end
    return hit;
  endfunction

  // random-mode writes only target locations on the allow-list
  assert_allow_only_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !mode_dir) |-> in_allow(req_addr));

  // a read always goes back to the address of the preceding write
  assert_read_same_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |-> (req_addr == u_fsm.cur_addr_q));

endmodule

// File: tb/wrbt_top_test.sv
module wrbt_top_test;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] seed = '0;
  logic [15:0] iter_count = '0;
  logic [7:0]  gap_cycles = '0;
  logic        directed = 1'b0;
  logic        req_valid, req_write;
  logic [7:0]  req_addr, req_wdata;
  logic        rsp_valid = 1'b0, rsp_nack = 1'b0;
  logic [7:0]  rsp_rdata = '0;
  logic [15:0] pass_count, fail_count;
  logic        done;
  logic [7:0]  last_fail_addr;

  wrbt_top uut (
    .clk(clk), .rst(rst), .start(start), .seed(seed), .iter_count(iter_count),
    .gap_cycles(gap_cycles), .directed(directed), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_rdata(rsp_rdata),
    .pass_count(pass_count), .fail_count(fail_count), .done(done),
    .last_fail_addr(last_fail_addr)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] tb_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [7:0] allow_at(input int i);
    case (i)
      0: return 8'h10; 1: return 8'h11; 2: return 8'h22; 3: return 8'h35;
      default: return 8'h4A;
    endcase
  endfunction

  function automatic logic [7:0] dir_at(input int i);
    case (i)
      0: return 8'h80; 1: return 8'h81;
      default: return 8'hC0;
    endcase
  endfunction

  // model state
  logic [15:0] m_s;
  int          m_it, m_gap;
  bit          m_dir;
  int          f_wnack, f_rnack, f_stuck;
  int          e_pass, e_fail, e_last;
  logic [7:0]  mem [256];
  logic [7:0]  w_addr, w_data;
  int          rsp_cyc;

  // bus engine model
  initial begin
    bit         nk;
    logic [7:0] rd;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    forever begin
      @(negedge clk);
      if (req_valid) begin
        rd = '0;
        if (req_write) begin
          logic [7:0] ea;
          ea = m_dir ? dir_at(m_it % 3) : allow_at(int'(m_s % 16'd5));
          chk(req_addr == ea, m_dir ? "R8 write address" : "R2 write address", req_addr, ea);
          chk(req_wdata == m_s[7:0], "R2 write data", req_wdata, m_s[7:0]);
          w_addr = req_addr; w_data = m_s[7:0];
          m_s = tb_step(m_s); m_it++;
          nk = (int'(req_addr) == f_wnack);
          if (nk) begin
            e_fail++; e_last = req_addr;
          end else begin
            mem[req_addr] = (int'(req_addr) == f_stuck) ? (req_wdata ^ 8'h01) : req_wdata;
          end
        end else begin
          chk(req_addr == w_addr, "R3 read address", req_addr, w_addr);
          chk(cyc - rsp_cyc == m_gap + 2, "R4 gap", cyc - rsp_cyc, m_gap + 2);
          nk = (int'(req_addr) == f_rnack);
          rd = mem[req_addr];
          if (nk || rd != w_data) begin
            e_fail++; e_last = req_addr;
          end else e_pass++;
        end
        repeat (LAT - 1) @(negedge clk);
        rsp_valid = 1'b1; rsp_nack = nk; rsp_rdata = rd; rsp_cyc = cyc;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_nack = 1'b0; rsp_rdata = '0;
      end
    end
  end

  task automatic run(input logic [15:0] sd, input int n, input int g, input bit dm,
                     input int wn, input int rn, input int st, input bit poke, input string tag);
    int t;
    m_s = (sd == 0) ? 16'h0001 : sd;
    m_it = 0; m_gap = g; m_dir = dm;
    f_wnack = wn; f_rnack = rn; f_stuck = st;
    e_pass = 0; e_fail = 0; e_last = 0;
    @(negedge clk);
    seed = sd; iter_count = 16'(n); gap_cycles = 8'(g); directed = dm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // clear evidence of the previous run (R1)
    chk(pass_count == 0 && fail_count == 0 && last_fail_addr == 0 || n == 0,
        {"R1 cleared ", tag}, {pass_count, fail_count}, 0);
    t = 0;
    while (!done && t < 20000) begin
      if (poke && t == 25) begin
        seed = 16'h5555; directed = ~dm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t++;
      end else begin
        @(negedge clk);
        t++;
      end
    end
    chk(done, {"R9 done seen ", tag}, done, 1);
    chk(pass_count == 16'(e_pass), {"R5 pass count ", tag}, pass_count, e_pass);
    chk(fail_count == 16'(e_fail), {"R5 fail count ", tag}, fail_count, e_fail);
    chk(last_fail_addr == 8'(e_last), {"R7 last fail ", tag}, last_fail_addr, e_last);
    chk(m_it == n, {"R3 iterations ", tag}, m_it, n);
    @(negedge clk);
    chk(!done, {"R9 done one cycle ", tag}, done, 0);
    repeat (6) @(negedge clk);
    chk(pass_count == 16'(e_pass) && fail_count == 16'(e_fail) && !req_valid,
        {"R9 hold ", tag}, {pass_count, fail_count}, {e_pass[15:0], e_fail[15:0]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !req_valid && pass_count == 0 && fail_count == 0 && last_fail_addr == 0,
        "R11 reset state", {done, req_valid, pass_count}, 0);
    rst = 1'b0;
    // clean random runs, several seeds and gaps
    run(16'hACE1, 20, 0, 0, -1, -1, -1, 0, "rnd g0");
    run(16'h1234, 12, 2, 0, -1, -1, -1, 0, "rnd g2");
    // zero seed substitution, write NACK and corrupted storage (R1, R6)
    run(16'h0000, 15, 3, 0, 'h35, -1, 'h22, 0, "R6 faults");
    // read NACK, corruption, clean runs (R5)
    run(16'hBEEF, 12, 1, 0, -1, 'h11, 'h4A, 0, "R5 faults");
    // directed mode (R8), read NACK on one directed address
    run(16'h00F0, 7, 1, 1, -1, 'h81, -1, 0, "R8 directed");
    run(16'h0F0F, 5, 4, 1, 'hC0, -1, 'h80, 0, "R8 directed faults");
    // same seed twice replays the same sequence (R2)
    run(16'hACE1, 8, 0, 0, -1, -1, -1, 0, "R2 replay");
    // start during run ignored (R10)
    run(16'h7777, 10, 2, 0, -1, -1, 'h10, 1, "R10 busy start");
    // zero iterations: done in the cycle after start (R9)
    @(negedge clk);
    iter_count = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && pass_count == 0 && fail_count == 0, "R9 zero iterations",
        {done, pass_count}, 32'h10000);
    @(negedge clk);
    chk(!done && !req_valid, "R9 zero iterations pulse", done, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule